// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices, A times B, on an N by N grid of multiply-accumulate cells. The default size is N = 3. Each cell keeps one element of the product in its own accumulator for the whole computation. A values move rightward along the grid rows and B values move downward along the grid columns, one cell per clock.

An edge feeder sits in front of the grid. It captures both operand matrices from wide parallel input buses on a start pulse. It then injects row i of A into grid row i and column j of B into grid column j. Each stream is delayed by its index, so that a[i][k] and b[k][j] meet in cell (i,j) during step i+j+k+1. The feeder drives zero wherever it has no valid operand.

A full product takes 3N-2 steps. A one-cycle done flag follows the last step. The results then stay unchanged until the next start.

Top module: `systolic_mm`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and all result fields are 0 until a start is given.
- R2: When `done` is high, result field (i,j) equals the unsigned sum over k of a[i][k]*b[k][j], using the operands captured at the start.
- R3: `done` is high for exactly one cycle. It is sampled high in the clock cycle that follows the 3N-2'th rising edge after the edge that sampled `start`, and it is low in every other cycle of the run.
- R4: After the s'th rising edge following the start edge, result field (i,j) holds the sum of a[i][k]*b[k][j] over all k with i+j+k+1 <= s. Cells therefore begin accumulating at step i+j+1, and absent operands contribute nothing.
- R5: The edge that samples `start` clears all accumulators and all inter-cell registers and captures `a_flat`/`b_flat`. Later changes on `a_flat`/`b_flat` have no effect on the run. A start during a run abandons that run and begins a fresh one.
- R6: After `done`, the result fields hold their values until the next start, whatever the operand inputs do.
- R7: The accumulators do not wrap. With every operand at its maximum value, each result equals N*(2^OPW-1)^2.
- R8: Operand a[i][k] occupies `a_flat[(i*N+k)*OPW +: OPW]`. Operand b[k][j] occupies `b_flat[(k*N+j)*OPW +: OPW]`. Result (i,j) occupies `c_flat[(i*N+j)*ACCW +: ACCW]`, where ACCW = 2*OPW + ceil(log2 N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures operands, clears the grid, begins a run |
| a_flat | input | N*N*OPW | Matrix A, row-major |
| b_flat | input | N*N*OPW | Matrix B, row-major |
| done | output | 1 | One-cycle flag after the last step |
| c_flat | output | N*N*ACCW | Product matrix, row-major |

## Verification
The bench compares every cell against the partial sum expected after every step of each run. A wrong skew or a feeder that injects stale values instead of zero therefore shows up as a cell that starts too early or picks up a stray product. Runs at full scale catch an accumulator that is too narrow, which would wrap. A start given in the middle of a run catches a design that fails to clear the grid pipeline, because left-over operands would leak into the new product. After each start the operand buses are scrambled, and after each done the bench idles. A design that reads the buses live, or keeps accumulating once the run has ended, would then return corrupted or drifting results.

// File: rtl/systolic_pkg.sv
package systolic_pkg;
  // accumulator width that holds n full-width products without wrapping
  function automatic int acc_width(input int opw, input int n);
    return 2 * opw + $clog2(n);
  endfunction

  // number of steps from first injection to last accumulation
  function automatic int run_steps(input int n);
    return 3 * n - 2;
  endfunction
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
  parameter int N = 3,
  localparam int STEPS = systolic_pkg::run_steps(N),
  localparam int SW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      step <= SW'(1);
      done <= 1'b0;
    end else if (busy) begin
      if (step == SW'(STEPS)) begin
        busy <= 1'b0;
        step <= '0;
        done <= 1'b1;
      end else begin
        step <= step + SW'(1);
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    step <= SW'(STEPS));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && step == SW'(STEPS)) |=> (done && !busy));

endmodule

// File: rtl/sa_feeder.sv
module sa_feeder #(
  parameter int N   = 3,
  parameter int OPW = 8,
  parameter int SW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N*N*OPW-1:0] a_flat,
  input  logic [N*N*OPW-1:0] b_flat,
  input  logic [SW-1:0]    step,
  output logic [N*OPW-1:0] row_inj,
  output logic [N*OPW-1:0] col_inj
);

  logic [OPW-1:0] a_m [N][N];
  logic [OPW-1:0] b_m [N][N];

  // operand store: plain load-enabled registers, no reset needed
  always_ff @(posedge clk) begin
    if (load) begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          a_m[r][c] <= a_flat[(r*N+c)*OPW +: OPW];
          b_m[r][c] <= b_flat[(r*N+c)*OPW +: OPW];
        end
      end
    end
  end

  // skewed injection: lane x, element k enters at step x+k+1
  always_comb begin
    row_inj = '0;
    col_inj = '0;
    for (int x = 0; x < N; x++) begin
      for (int k = 0; k < N; k++) begin
        if (int'(step) == x + k + 1) begin
          row_inj[x*OPW +: OPW] = a_m[x][k];
          col_inj[x*OPW +: OPW] = b_m[k][x];
        end
      end
    end
  end

  // R4
  idle_inject_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |-> (row_inj == '0 && col_inj == '0));

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int OPW  = 8,
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic [OPW-1:0]  a_in,
  input  logic [OPW-1:0]  b_in,
  output logic [OPW-1:0]  a_out,
  output logic [OPW-1:0]  b_out,
  output logic [ACCW-1:0] acc
);

  logic [2*OPW-1:0] prod;

  assign prod = {{OPW{1'b0}}, a_in} * {{OPW{1'b0}}, b_in};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else if (en) begin
      a_out <= a_in;
      b_out <= b_in;
      acc   <= acc + ACCW'(prod);
    end
  end

  // R7
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (acc >= $past(acc)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc));

endmodule

// File: rtl/systolic_mm.sv
module systolic_mm #(
  parameter int N   = 3,
  parameter int OPW = 8,
  localparam int ACCW  = systolic_pkg::acc_width(OPW, N),
  localparam int STEPS = systolic_pkg::run_steps(N),
  localparam int SW    = $clog2(STEPS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N*N*OPW-1:0]  a_flat,
  input  logic [N*N*OPW-1:0]  b_flat,
  output logic                done,
  output logic [N*N*ACCW-1:0] c_flat
);

  logic          busy;
  logic [SW-1:0] step;
  logic [N*OPW-1:0] row_inj;
  logic [N*OPW-1:0] col_inj;

  sa_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .step(step), .done(done)
  );

  sa_feeder #(.N(N), .OPW(OPW), .SW(SW)) u_feed (
    .clk(clk), .rst(rst), .load(start),
    .a_flat(a_flat), .b_flat(b_flat), .step(step),
    .row_inj(row_inj), .col_inj(col_inj)
  );

  // horizontal links: a_w[r][c] feeds cell (r,c); column N is the east edge
  logic [OPW-1:0]  a_w   [N][N+1];
  // vertical links: b_w[r][c] feeds cell (r,c); row N is the south edge
  logic [OPW-1:0]  b_w   [N+1][N];
  logic [ACCW-1:0] acc_w [N][N];

  for (genvar e = 0; e < N; e++) begin : g_edge
    assign a_w[e][0] = row_inj[e*OPW +: OPW];
    assign b_w[0][e] = col_inj[e*OPW +: OPW];

    // R5
    edge_flush_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (a_w[e][N] == '0 && b_w[N][e] == '0));
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sa_pe #(.OPW(OPW), .ACCW(ACCW)) u_pe (
        .clk(clk), .rst(rst), .clr(start), .en(busy),
        .a_in(a_w[r][c]), .b_in(b_w[r][c]),
        .a_out(a_w[r][c+1]), .b_out(b_w[r+1][c]),
        .acc(acc_w[r][c])
      );
      assign c_flat[(r*N+c)*ACCW +: ACCW] = acc_w[r][c];
    end
  end

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (c_flat == '0));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(c_flat));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && c_flat == '0));

endmodule

// File: tb/sim_systolic_mm.sv
module sim_systolic_mm;
  localparam int N     = 3;
  localparam int OPW   = 8;
  localparam int ACCW  = 2 * OPW + $clog2(N);
  localparam int STEPS = 3 * N - 2;
  localparam int MAXV  = (1 << OPW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N*N*OPW-1:0]  a_flat = '0;
  logic [N*N*OPW-1:0]  b_flat = '0;
  logic                done;
  logic [N*N*ACCW-1:0] c_flat;

  int n_checks = 0;
  int n_fail   = 0;
  int am [N][N];
  int bm [N][N];

  always #10 clk = ~clk;

  systolic_mm #(.N(N), .OPW(OPW)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .a_flat(a_flat), .b_flat(b_flat),
    .done(done), .c_flat(c_flat)
  );

  function automatic longint exp_cell(int i, int j, int s);
    longint sum = 0;
    for (int k = 0; k < N; k++)
      if (i + j + k + 1 <= s) sum += longint'(am[i][k]) * longint'(bm[k][j]);
    return sum;
  endfunction

  function automatic longint got_cell(int i, int j);
    return longint'(c_flat[(i*N+j)*ACCW +: ACCW]);
  endfunction

  task automatic check_cells(int s, string req);
    bit bad = 0;
    n_checks++;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (!bad && got_cell(i, j) != exp_cell(i, j, s)) begin
          bad = 1;
          $display("FAIL %s step %0d cell(%0d,%0d): actual %0d expected %0d",
                   req, s, i, j, got_cell(i, j), exp_cell(i, j, s));
        end
    if (bad) n_fail++;
  endtask

  task automatic check_done(bit expv, string req);
    n_checks++;
    if (done !== expv) begin
      n_fail++;
      $display("FAIL %s done: actual %0b expected %0b", req, done, expv);
    end
  endtask

  task automatic pack_ops();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        a_flat[(i*N+j)*OPW +: OPW] = OPW'(am[i][j]);
        b_flat[(i*N+j)*OPW +: OPW] = OPW'(bm[i][j]);
      end
  endtask

  task automatic scramble();
    for (int x = 0; x < N*N; x++) begin
      a_flat[x*OPW +: OPW] = OPW'($urandom_range(0, MAXV));
      b_flat[x*OPW +: OPW] = OPW'($urandom_range(0, MAXV));
    end
  endtask

  // called at a negedge; stop_at > 0 abandons the run after that step
  task automatic run_mm(int stop_at);
    pack_ops();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();                       // R5: inputs ignored after capture
    check_cells(0, "R5");
    check_done(1'b0, "R3");
    for (int s = 1; s <= STEPS; s++) begin
      @(negedge clk);
      check_cells(s, (s == STEPS) ? "R2" : "R4");
      check_done(s == STEPS, "R3");
      if (s == stop_at) return;
    end
    @(negedge clk);
    check_done(1'b0, "R3");
    scramble();
    repeat (3) @(negedge clk);
    check_cells(STEPS, "R6");
  endtask

  task automatic set_random();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = $urandom_range(0, MAXV);
        bm[i][j] = $urandom_range(0, MAXV);
      end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R3 watchdog expired: actual hung expected finished");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_done(1'b0, "R1");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin am[i][j] = 0; bm[i][j] = 0; end
    check_cells(0, "R1");
    rst = 1'b0;
    @(negedge clk);
    check_done(1'b0, "R1");
    check_cells(0, "R1");

    // R8: distinct values per position expose any packing mix-up
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = 1 + i * N + j;
        bm[i][j] = 10 * (i + 1) + j;
      end
    run_mm(0);

    // identity times B
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = (i == j) ? 1 : 0;
        bm[i][j] = $urandom_range(0, MAXV);
      end
    run_mm(0);

    // R7: full scale, no wrap
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin am[i][j] = MAXV; bm[i][j] = MAXV; end
    run_mm(0);
    n_checks++;
    if (got_cell(N-1, N-1) != longint'(N) * MAXV * MAXV) begin
      n_fail++;
      $display("FAIL R7 full scale: actual %0d expected %0d",
               got_cell(N-1, N-1), longint'(N) * MAXV * MAXV);
    end

    // R5: abandon a run mid-way, restart with new operands
    set_random();
    run_mm(4);
    set_random();
    run_mm(0);

    // restart right as done is high
    set_random();
    run_mm(STEPS);
    set_random();
    run_mm(0);

    for (int t = 0; t < 20; t++) begin
      set_random();
      run_mm(0);
    end
    report();
  end
endmodule